// File: doc/BRIEF.md
# PIPE Power-State Transition Gate

This block sits between the link state machine of a SuperSpeed USB port and the PowerDown control of a PIPE PHY. When the link asks to enter U1, U2 or U3, the block requests the matching PHY power state P1, P2 or P3. When the link asks to leave that low-power state, the block returns the PHY to P0. It drives only one PowerDown change at a time. Each change is held until the PHY acknowledges it with a single-cycle PhyStatus pulse. A one-cycle done pulse then tells the link state machine that the step has finished.

When delay mode is on, an entry request does not reach the PHY at once. The block keeps PowerDown at P0 until one of three things happens. The first is that the receiver reports electrical idle while RxValid is low. The second is that RxValid falls. The third is that a configured multiple of eight 8b/10b decode errors has been counted. A second configuration bit selects how exit works: exit can run with the PHY already back in P0, or it can start in the low-power state, with P0 requested only once exit signalling shows up on the line.

Top module: `pipe_pd_gate`

## Requirements
- R1: PowerDown is a 2-bit code: P0=2'b00, P1=2'b01, P2=2'b10, P3=2'b11. Link target code 1, 2 or 3 (U1, U2, U3) maps to PowerDown 1, 2 or 3. After reset, PowerDown is P0 and done is low.
- R2: With delay mode off, an accepted entry request drives PowerDown to the target code on the clock edge that accepts it. The receive inputs are not checked.
- R3: With delay mode on, PowerDown stays P0 until a cycle in which RxElecIdle is 1 and RxValid is 0. PowerDown changes to the target on that edge.
- R4: With delay mode on, a 1-to-0 transition of RxValid also releases the held entry on the edge where RxValid is first seen low.
- R5: With delay mode on and the 3-bit threshold N non-zero, the held entry is released on the edge after the (8·N)-th decode-error strobe has been counted. N=0 disables this release. The error count saturates, and it is cleared whenever a new entry request is accepted.
- R6: While a PowerDown change awaits PhyStatus, PowerDown does not change. The PhyStatus pulse that acknowledges a Px entry or a return to P0 produces exactly one done cycle on the following edge.
- R7: With exit mode 0, an exit request in Px drives PowerDown to P0 on the next edge. The PhyStatus acknowledge then gives done.
- R8: With exit mode 1, an exit request in Px leaves PowerDown at Px while RxElecIdle is 1. P0 is driven on the first edge where RxElecIdle is 0.
- R9: An exit request while a delayed entry is still held cancels the entry. PowerDown stays P0 and no done pulse is given.
- R10: An exit request that arrives while the Px entry awaits PhyStatus is remembered. It is acted on in the cycle after that acknowledge.
- R11: An entry request is ignored unless the link is in U0 with no transition under way. A target code of 0 is always ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ux_enter | input | 1 | Link requests entry into a low-power state (pulse) |
| ux_target | input | 2 | Requested low-power state: 1=U1, 2=U2, 3=U3 |
| ux_exit | input | 1 | Link requests exit from the low-power state (pulse) |
| rx_elec_idle | input | 1 | PHY receiver electrical idle |
| rx_valid | input | 1 | PHY receive data valid |
| rx_dec_err | input | 1 | 8b/10b decode error strobe |
| phy_status | input | 1 | PHY power-change acknowledge pulse |
| cfg_delay_en | input | 1 | Hold entry until the receive path is quiet |
| cfg_err_thresh | input | 3 | Decode-error release threshold, in units of 8 |
| cfg_exit_in_px | input | 1 | 1: begin exit while still in Px |
| power_down | output | 2 | PIPE PowerDown request |
| done | output | 1 | One-cycle pulse when the PHY acknowledges the final state |

## Verification
Several properties are checked by assertions on every cycle. Px is only ever reached from P0. PowerDown stays unchanged while an acknowledge is pending. Every done pulse follows a PhyStatus pulse. A held entry keeps P0 while no release condition is present. A cancel leaves P0 with no done pulse. Some behaviours can only be shown by the bench scenarios: the exact edge on which each release condition takes effect, the 8·N error count and how it clears between requests, the choice of exit mode, and the handling of an exit that arrives during the acknowledge wait. The bench sweeps every target and both exit modes, and covers thresholds 1 to 3.

// File: rtl/pipe_pd_gate.sv
module pipe_pd_gate #(
  parameter int THR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ux_enter,
  input  logic [1:0]       ux_target,
  input  logic             ux_exit,
  input  logic             rx_elec_idle,
  input  logic             rx_valid,
  input  logic             rx_dec_err,
  input  logic             phy_status,
  input  logic             cfg_delay_en,
  input  logic [THR_W-1:0] cfg_err_thresh,
  input  logic             cfg_exit_in_px,
  output logic [1:0]       power_down,
  output logic             done
);

  localparam int CNT_W = THR_W + 3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [2:0] {
    S_U0, S_HOLD, S_ENT, S_LOW, S_XPX, S_XIT
  } st_t;

  st_t              st;
  logic [1:0]       tgt;
  logic [CNT_W-1:0] cnt;
  logic             rv_q;
  logic             pend;

  wire quiet   = rx_elec_idle && !rx_valid;
  wire rv_fall = rv_q && !rx_valid;
  wire err_hit = (cfg_err_thresh != '0) && (cnt >= {cfg_err_thresh, 3'b000});
  wire release_ok = !cfg_delay_en || quiet || rv_fall || err_hit;
  wire go_enter = ux_enter && (ux_target != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_U0;
      power_down <= 2'b00;
      tgt        <= 2'b00;
      cnt        <= '0;
      rv_q       <= 1'b0;
      pend       <= 1'b0;
      done       <= 1'b0;
    end else begin
      rv_q <= rx_valid;
      done <= 1'b0;
      case (st)
        S_U0: if (go_enter) begin
          tgt  <= ux_target;
          cnt  <= '0;
          pend <= 1'b0;
          if (!cfg_delay_en) begin
            power_down <= ux_target;
            st         <= S_ENT;
          end else begin
            st <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (ux_exit) begin
            st <= S_U0;
          end else if (release_ok) begin
            power_down <= tgt;
            st         <= S_ENT;
          end else if (rx_dec_err && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ENT: begin
          if (ux_exit) pend <= 1'b1;
          if (phy_status) begin
            done <= 1'b1;
            st   <= S_LOW;
          end
        end
        S_LOW: if (ux_exit || pend) begin
          pend <= 1'b0;
          if (cfg_exit_in_px) begin
            st <= S_XPX;
          end else begin
            power_down <= 2'b00;
            st         <= S_XIT;
          end
        end
        S_XPX: if (!rx_elec_idle) begin
          power_down <= 2'b00;
          st         <= S_XIT;
        end
        S_XIT: if (phy_status) begin
          done <= 1'b1;
          st   <= S_U0;
        end
        default: st <= S_U0;
      endcase
    end
  end

  a_r1_px_from_p0: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(power_down) && power_down != 2'b00) |-> $past(power_down) == 2'b00);

  a_r1_entry_code: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ENT) |-> power_down == tgt);

  a_r2_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_U0 && go_enter && !cfg_delay_en) |=> power_down == $past(ux_target));

  a_r3_hold_p0: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && !ux_exit && cfg_delay_en && !quiet && !rv_fall && !err_hit)
      |=> power_down == 2'b00);

  a_r6_wait_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_ENT || st == S_XIT) && !phy_status) |=> $stable(power_down));

  a_r6_done_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(phy_status));

  a_r8_px_exit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XPX && rx_elec_idle) |=> $stable(power_down));

  a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && ux_exit) |=> (power_down == 2'b00 && !done));

endmodule

// File: tb/sim_pipe_pd_gate.sv
module sim_pipe_pd_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ux_enter = 1'b0;
  logic [1:0] ux_target = 2'b00;
  logic       ux_exit = 1'b0;
  logic       rx_elec_idle = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_dec_err = 1'b0;
  logic       phy_status = 1'b0;
  logic       cfg_delay_en = 1'b1;
  logic [2:0] cfg_err_thresh = 3'd0;
  logic       cfg_exit_in_px = 1'b0;
  logic [1:0] power_down;
  logic       done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pipe_pd_gate u0 (
    .clk(clk), .rst_n(rst_n), .ux_enter(ux_enter), .ux_target(ux_target),
    .ux_exit(ux_exit), .rx_elec_idle(rx_elec_idle), .rx_valid(rx_valid),
    .rx_dec_err(rx_dec_err), .phy_status(phy_status), .cfg_delay_en(cfg_delay_en),
    .cfg_err_thresh(cfg_err_thresh), .cfg_exit_in_px(cfg_exit_in_px),
    .power_down(power_down), .done(done)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic enter(input logic [1:0] t);
    ux_enter = 1'b1; ux_target = t; tick(); ux_enter = 1'b0;
  endtask

  task automatic ack();
    phy_status = 1'b1; tick(); phy_status = 1'b0;
  endtask

  task automatic leave_p0();
    cfg_exit_in_px = 1'b0;
    ux_exit = 1'b1; tick(); ux_exit = 1'b0;
    chk(power_down, 0, "R7 exit to P0");
    ack();
    chk(done, 1, "R7 done on exit ack");
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected 0", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin
    repeat (3) tick();
    chk(power_down, 0, "R1 reset PowerDown");
    chk(done, 0, "R1 reset done");
    rst_n = 1'b1;
    tick();

    // Immediate entry, both exit modes, every target
    cfg_delay_en = 1'b0;
    for (int t = 1; t <= 3; t++) begin
      for (int xm = 0; xm <= 1; xm++) begin
        rx_elec_idle = 1'b0; rx_valid = 1'b1;
        enter(2'(t));
        chk(power_down, t, "R2 immediate entry code");
        chk(done, 0, "R6 no done before ack");
        tick();
        chk(power_down, t, "R6 held awaiting ack");
        ack();
        chk(done, 1, "R6 done on entry ack");
        tick();
        chk(done, 0, "R6 done one cycle");
        cfg_exit_in_px = xm[0];
        rx_elec_idle = 1'b1;
        ux_exit = 1'b1; tick(); ux_exit = 1'b0;
        if (xm == 0) begin
          chk(power_down, 0, "R7 exit in P0");
        end else begin
          chk(power_down, t, "R8 exit stays Px");
          tick(); tick();
          chk(power_down, t, "R8 Px while idle");
          rx_elec_idle = 1'b0;
          tick();
          chk(power_down, 0, "R8 P0 after idle drops");
        end
        tick();
        chk(power_down, 0, "R6 P0 held awaiting ack");
        ack();
        chk(done, 1, "R6 done on exit ack");
        tick();
      end
    end

    cfg_delay_en = 1'b1;
    for (int t = 1; t <= 3; t++) begin
      // R3: quiet receiver releases
      cfg_err_thresh = 3'd0; rx_valid = 1'b0; rx_elec_idle = 1'b0;
      tick();
      enter(2'(t));
      chk(power_down, 0, "R3 held at P0");
      repeat (3) tick();
      chk(power_down, 0, "R3 still held");
      rx_elec_idle = 1'b1;
      tick();
      chk(power_down, t, "R3 released on idle");
      ack();
      leave_p0();

      // R4: RxValid falling releases
      rx_valid = 1'b1; rx_elec_idle = 1'b0;
      tick();
      enter(2'(t));
      repeat (4) tick();
      chk(power_down, 0, "R4 held while valid");
      rx_valid = 1'b0;
      tick();
      chk(power_down, t, "R4 released on RxValid fall");
      ack();
      rx_valid = 1'b1;
      leave_p0();

      // R5: error threshold 8*N
      for (int n = 1; n <= 3; n++) begin
        cfg_err_thresh = 3'(n); rx_valid = 1'b1; rx_elec_idle = 1'b0;
        enter(2'(t));
        rx_dec_err = 1'b1;
        repeat (8 * n) tick();
        rx_dec_err = 1'b0;
        chk(power_down, 0, "R5 held at 8N errors counted");
        tick();
        chk(power_down, t, "R5 released after 8N errors");
        ack();
        leave_p0();
      end
    end

    // R5: N=0 disables error release
    cfg_err_thresh = 3'd0; rx_valid = 1'b1; rx_elec_idle = 1'b0;
    enter(2'd2);
    rx_dec_err = 1'b1;
    repeat (20) tick();
    rx_dec_err = 1'b0;
    tick();
    chk(power_down, 0, "R5 threshold 0 never releases");
    // R9: cancel while held
    ux_exit = 1'b1; tick(); ux_exit = 1'b0;
    chk(power_down, 0, "R9 cancel keeps P0");
    chk(done, 0, "R9 cancel no done");
    tick();
    chk(done, 0, "R9 cancel no done later");

    // R5: counter clears on new request
    cfg_err_thresh = 3'd1;
    enter(2'd3);
    rx_dec_err = 1'b1; repeat (5) tick(); rx_dec_err = 1'b0;
    ux_exit = 1'b1; tick(); ux_exit = 1'b0;
    chk(power_down, 0, "R9 cancel with errors");
    enter(2'd3);
    rx_dec_err = 1'b1; repeat (4) tick(); rx_dec_err = 1'b0;
    tick();
    chk(power_down, 0, "R5 count cleared on new entry");
    rx_dec_err = 1'b1; repeat (4) tick(); rx_dec_err = 1'b0;
    chk(power_down, 0, "R5 eight errors just counted");
    tick();
    chk(power_down, 3, "R5 release after cleared count");
    ack();
    // R11: entry ignored while in Px
    enter(2'd1);
    tick();
    chk(power_down, 3, "R11 entry ignored in Px");
    leave_p0();

    // R10: exit during entry acknowledge wait
    cfg_delay_en = 1'b0; cfg_exit_in_px = 1'b0;
    enter(2'd2);
    ux_exit = 1'b1; tick(); ux_exit = 1'b0;
    chk(power_down, 2, "R10 Px kept until ack");
    ack();
    chk(done, 1, "R10 entry done");
    chk(power_down, 2, "R10 still Px at ack");
    tick();
    chk(power_down, 0, "R10 remembered exit acted on");
    ack();
    chk(done, 1, "R10 exit done");
    tick();

    // R11: target 0 ignored
    enter(2'd0);
    repeat (3) tick();
    chk(power_down, 0, "R11 target 0 ignored");
    ack();
    chk(done, 0, "R11 no done for ignored request");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule